// File: doc/BRIEF.md
# IO Port Register Bank

This block watches a microprocessor bus that it samples in a faster system clock. It decodes the IO cycles for every one of the 256 port numbers. The bus clock, the IO request, read, write and opcode-fetch lines, the low address byte and the data byte all pass together through the same synchronizer stages, so they stay aligned with each other. Inside the system clock domain, the block finds the rising edges of the bus clock and counts them.

For a port write, the block waits a set number of bus-clock rises after it first sees the command. It then samples the data byte into that port's holding register and pulses that port's bit in a 256-bit write strobe vector. A port read follows the same timing and pulses that port's bit in a 256-bit read strobe vector. If the port number falls inside a configured inclusive window, the block also drives the byte from that port's input lane onto its data output, with an output enable, until the read command goes away.

The bus side is a sampled, free-running interface that carries no back-pressure. All pins are plain control and data pins, and the block has no valid/ready handshake.

Top module: `iob_port_bank`

## Requirements
- R1: An IO cycle starts only when the sampled IO request line is low, the read or write line is low, and the opcode-fetch line is high. While the opcode-fetch line is low, no strobe fires, no holding register changes and `data_oe` stays 0.
- R2: A completed write makes `wr_strobe` hold exactly one bit set, at index equal to the port number, for exactly one system cycle. This happens once per bus cycle, however long the command stays asserted.
- R3: A completed write to port p loads the sampled data byte into `wr_data[8p+7:8p]`. Every other port's byte keeps its value until that port is itself written.
- R4: A completed read of port p makes `rd_strobe` bit p high for exactly one system cycle per bus cycle, with all other bits 0.
- R5: `data_oe` is 1 only for a read whose latched port lies in the inclusive window RD_BEGIN..RD_END (default 240..249). It is high from the read strobe cycle until two cycles after the read command is removed. While it is high, `data_o` equals `rd_port_data[8p+7:8p]`; otherwise `data_o` is 0.
- R6: The read response fires after RD_DELAY bus-clock rises (default 2) that come strictly after the command input. With both counted as the input presented before some system edge k, the strobe is registered at edge k+3. For RD_DELAY=0 the trigger is the command itself.
- R7: Write data is sampled, and `wr_strobe` fires, after WR_DELAY bus-clock rises (default 2), with the same latency rule as R6.
- R8: The port number is taken from `addr` when the command is first detected. Changes on `addr` later in the same cycle have no effect.
- R9: If the command is removed before the delay has elapsed, the bus cycle ends with no strobe, no `data_oe` and no holding-register change.
- R10: After reset, both strobe vectors, every holding register, `data_oe` and `data_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_clk | input | 1 | Bus clock, sampled in clk |
| iorq_n | input | 1 | IO request, active low |
| rd_n | input | 1 | Read command, active low |
| wr_n | input | 1 | Write command, active low |
| m1_n | input | 1 | Opcode-fetch / acknowledge marker, active low |
| addr | input | PORT_W | Low address bits (port number) |
| data_i | input | DATA_W | Bus data byte for writes |
| wr_strobe | output | 2^PORT_W | One-hot per-port write pulse |
| wr_data | output | 2^PORT_W*DATA_W | Per-port holding registers, port p at bits 8p+7:8p |
| rd_strobe | output | 2^PORT_W | One-hot per-port read pulse |
| rd_port_data | input | 2^PORT_W*DATA_W | Per-port read bytes, port p at bits 8p+7:8p |
| data_o | output | DATA_W | Read data toward the bus, 0 when not enabled |
| data_oe | output | 1 | Read data output enable |

## Verification
A strobe is due exactly four samples after its trigger input is driven. The trigger is the command for a zero delay, or the D-th bus-clock rise that comes after the command. The bench drives the bus clock itself, counts those rises, and compares both strobe vectors in every cycle, so a strobe that arrives early, late, twice or on the wrong port all fail. `data_oe` and `data_o` are expected from the strobe sample through the second sample after the command is removed. The complete holding-register vector is compared against a model after every bus cycle, over sweeps of all 256 ports in both directions, with the address scrambled after the command has been latched.

// File: rtl/iob_pkg.sv
package iob_pkg;

  typedef struct packed {
    logic bclk;
    logic iorq_n;
    logic rd_n;
    logic wr_n;
    logic m1_n;
  } bus_ctl_t;

  localparam int CTL_W = $bits(bus_ctl_t);

  localparam bus_ctl_t CTL_IDLE = '{bclk: 1'b0, iorq_n: 1'b1, rd_n: 1'b1,
                                    wr_n: 1'b1, m1_n: 1'b1};

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_COUNT = 2'd1,
    SQ_DONE  = 2'd2
  } seq_state_t;

endpackage

// File: rtl/iob_bus_sampler.sv
module iob_bus_sampler
  import iob_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_clk,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              m1_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output bus_ctl_t          ctl_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              bclk_rise_o
);

  localparam int W = CTL_W + ADDR_W + DATA_W;
  localparam logic [W-1:0] RST_VAL = {CTL_IDLE, {ADDR_W{1'b0}}, {DATA_W{1'b0}}};

  logic [W-1:0] pipe [STAGES];
  logic [W-1:0] raw;
  logic         bclk_q;

  assign raw = {bus_clk, iorq_n, rd_n, wr_n, m1_n, addr, data};

  // Whole bus bundle moves through the same stages so fields stay aligned
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= RST_VAL;
        else        pipe[s] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= RST_VAL;
        else        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign {ctl_o, addr_o, data_o} = pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_q <= 1'b0;
    else        bclk_q <= ctl_o.bclk;
  end

  assign bclk_rise_o = ctl_o.bclk & ~bclk_q;

  // R6: a rise lasts one cycle since the previous level is remembered
  p_rise_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_rise_o |=> !bclk_rise_o);

endmodule

// File: rtl/iob_cycle_seq.sv
module iob_cycle_seq
  import iob_pkg::*;
#(
  parameter int DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_i,
  input  logic bclk_rise_i,
  output logic start_o,
  output logic fire_o
);

  localparam int CW = $clog2(DELAY + 2);
  localparam logic [CW-1:0] LAST = CW'(DELAY);

  seq_state_t    state;
  logic [CW-1:0] cnt;

  assign start_o = (state == SQ_IDLE) && cmd_i;
  assign fire_o  = (state == SQ_COUNT) && cmd_i && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (cmd_i) begin
            state <= SQ_COUNT;
            cnt   <= '0;
          end
        end
        SQ_COUNT: begin
          if (!cmd_i)            state <= SQ_IDLE;
          else if (cnt == LAST)  state <= SQ_DONE;
          else if (bclk_rise_i)  cnt   <= cnt + 1'b1;
        end
        SQ_DONE: begin
          if (!cmd_i) state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R6/R7: the count never passes the configured delay
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R9: a dropped command while waiting returns to idle without firing
  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_COUNT && !cmd_i) |=> (state == SQ_IDLE));

  // R2/R4: after firing, no second fire until a new command
  p_one_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);

endmodule

// File: rtl/iob_port_bank.sv
module iob_port_bank
  import iob_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int DATA_W      = 8,
  parameter int RD_BEGIN    = 240,
  parameter int RD_END      = 249,
  parameter int RD_DELAY    = 2,
  parameter int WR_DELAY    = 2,
  parameter int SYNC_STAGES = 2,
  localparam int NPORTS     = 1 << PORT_W,
  localparam int BANK_W     = NPORTS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_clk,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              m1_n,
  input  logic [PORT_W-1:0] addr,
  input  logic [DATA_W-1:0] data_i,
  output logic [NPORTS-1:0] wr_strobe,
  output logic [BANK_W-1:0] wr_data,
  output logic [NPORTS-1:0] rd_strobe,
  input  logic [BANK_W-1:0] rd_port_data,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe
);

  bus_ctl_t          s_ctl;
  logic [PORT_W-1:0] s_addr;
  logic [DATA_W-1:0] s_data;
  logic              bclk_rise;

  iob_bus_sampler #(
    .ADDR_W (PORT_W),
    .DATA_W (DATA_W),
    .STAGES (SYNC_STAGES)
  ) u_sampler (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_clk     (bus_clk),
    .iorq_n      (iorq_n),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .m1_n        (m1_n),
    .addr        (addr),
    .data        (data_i),
    .ctl_o       (s_ctl),
    .addr_o      (s_addr),
    .data_o      (s_data),
    .bclk_rise_o (bclk_rise)
  );

  // IO cycle decode; acknowledge cycles (m1 low) are excluded
  logic cmd_rd, cmd_wr;
  assign cmd_rd = ~s_ctl.iorq_n & ~s_ctl.rd_n & s_ctl.m1_n;
  assign cmd_wr = ~s_ctl.iorq_n & ~s_ctl.wr_n & s_ctl.m1_n;

  logic rd_start, rd_fire, wr_start, wr_fire;

  iob_cycle_seq #(.DELAY(RD_DELAY)) u_rd_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd_rd),
    .bclk_rise_i (bclk_rise),
    .start_o     (rd_start),
    .fire_o      (rd_fire)
  );

  iob_cycle_seq #(.DELAY(WR_DELAY)) u_wr_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd_wr),
    .bclk_rise_i (bclk_rise),
    .start_o     (wr_start),
    .fire_o      (wr_fire)
  );

  // Port numbers captured once per bus cycle
  logic [PORT_W-1:0] rd_port_q, wr_port_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_port_q <= '0;
      wr_port_q <= '0;
    end else begin
      if (rd_start) rd_port_q <= s_addr;
      if (wr_start) wr_port_q <= s_addr;
    end
  end

  // One-hot strobes, one system cycle each
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_strobe <= '0;
      rd_strobe <= '0;
    end else begin
      wr_strobe <= wr_fire ? (NPORTS'(1) << wr_port_q) : '0;
      rd_strobe <= rd_fire ? (NPORTS'(1) << rd_port_q) : '0;
    end
  end

  // Per-port holding registers
  for (genvar p = 0; p < NPORTS; p++) begin : g_hold
    logic [DATA_W-1:0] hold_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  hold_q <= '0;
      else if (wr_fire && wr_port_q == PORT_W'(p)) hold_q <= s_data;
    end
    assign wr_data[p*DATA_W +: DATA_W] = hold_q;
  end

  // Read return path, limited to the readable window
  logic              in_win;
  logic [DATA_W-1:0] rd_sel;

  assign in_win = (rd_port_q >= PORT_W'(RD_BEGIN)) && (rd_port_q <= PORT_W'(RD_END));
  assign rd_sel = rd_port_data[int'(rd_port_q)*DATA_W +: DATA_W];

  logic oe_next;
  always_comb begin
    if (rd_fire)     oe_next = in_win;
    else if (cmd_rd) oe_next = data_oe;
    else             oe_next = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_oe <= 1'b0;
      data_o  <= '0;
    end else begin
      data_oe <= oe_next;
      data_o  <= oe_next ? rd_sel : '0;
    end
  end

  // R2: write strobe has at most one bit and never two cycles in a row
  p_wr_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_strobe));
  p_wr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe != '0) |=> (wr_strobe == '0));

  // R4: same for the read strobe
  p_rd_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_strobe));
  p_rd_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe != '0) |=> (rd_strobe == '0));

  // R3: holding registers move only on a write fire
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_fire) |-> $stable(wr_data));

  // R5: output enable only inside the window; data quiet when disabled
  p_oe_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> in_win);
  p_data_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_o == '0));

  // R8: port numbers change only when a new cycle starts
  p_rd_port_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_start) |-> $stable(rd_port_q));
  p_wr_port_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_start) |-> $stable(wr_port_q));

  // R1: no cycle start while the opcode-fetch marker is low
  p_m1_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ctl.m1_n |-> (!rd_start && !wr_start));

endmodule

// File: tb/iob_port_bank_bench.sv
module iob_port_bank_bench;

  localparam int PW  = 8;
  localparam int DW  = 8;
  localparam int NP  = 1 << PW;
  localparam int RB  = 240;
  localparam int RE  = 249;
  localparam int RDD = 2;
  localparam int WRD = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_clk = 1'b0;
  logic              iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
  logic [PW-1:0]     addr = '0;
  logic [DW-1:0]     data_i = '0;
  logic [NP-1:0]     wr_strobe, rd_strobe;
  logic [NP*DW-1:0]  wr_data, rd_port_data, model;
  logic [DW-1:0]     data_o;
  logic              data_oe;

  int checks = 0;
  int errors = 0;
  int phase  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  iob_port_bank #(
    .PORT_W(PW), .DATA_W(DW), .RD_BEGIN(RB), .RD_END(RE),
    .RD_DELAY(RDD), .WR_DELAY(WRD), .SYNC_STAGES(2)
  ) u_iob_port_bank (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .iorq_n(iorq_n),
    .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n), .addr(addr), .data_i(data_i),
    .wr_strobe(wr_strobe), .wr_data(wr_data), .rd_strobe(rd_strobe),
    .rd_port_data(rd_port_data), .data_o(data_o), .data_oe(data_oe)
  );

  function automatic logic [DW-1:0] rd_pat(int p);
    return DW'((p * 3) ^ 8'h5A);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [NP-1:0] act, logic [NP-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Advance bus clock (period 8 system cycles); returns 1 on a rising edge
  task automatic bus_step(output bit rose);
    phase = (phase + 1) % 8;
    rose  = (phase == 4);
    bus_clk = (phase >= 4);
  endtask

  // One bus cycle. Outputs are sampled at each negedge before inputs change.
  task automatic io_cycle(bit is_wr, int port, logic [DW-1:0] val, int hold, bit m1, string req);
    int  dly   = is_wr ? WRD : RDD;
    int  rises = 0;
    int  trig  = (dly == 0) ? 0 : -1;
    bit  valid;
    bit  rose;
    bit  win   = (port >= RB) && (port <= RE);
    logic [NP-1:0] onehot = NP'(1) << port;
    for (int i = 0; i < hold + 10; i++) begin
      @(negedge clk);
      valid = m1 && (trig >= 0) && (trig <= hold - 2);
      // strobe checks (R2/R4 timing per R6/R7)
      if (is_wr) begin
        chk(wr_strobe == ((valid && i == trig + 4) ? onehot : '0), req, "wr_strobe",
            wr_strobe, (valid && i == trig + 4) ? onehot : '0);
        chk(rd_strobe == '0, req, "rd_strobe idle", rd_strobe, '0);
        chk(data_oe == 1'b0, req, "data_oe on write", NP'(data_oe), '0);
      end else begin
        logic exp_oe;
        exp_oe = valid && win && (i >= trig + 4) && (i <= hold + 2);
        chk(rd_strobe == ((valid && i == trig + 4) ? onehot : '0), req, "rd_strobe",
            rd_strobe, (valid && i == trig + 4) ? onehot : '0);
        chk(wr_strobe == '0, req, "wr_strobe idle", wr_strobe, '0);
        chk(data_oe == exp_oe, "R5", "data_oe", NP'(data_oe), NP'(exp_oe));
        chk(data_o == (exp_oe ? rd_pat(port) : '0), "R5", "data_o",
            NP'(data_o), NP'(exp_oe ? rd_pat(port) : 8'h00));
      end
      // drive
      if (i == 0) begin
        addr   = PW'(port);
        data_i = val;
        iorq_n = 1'b0;
        m1_n   = m1;
        if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
      end
      if (i == 3) addr = PW'(port) ^ PW'(8'hFF);   // R8: late address change
      if (i == hold) begin
        iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1;
      end
      bus_step(rose);
      if (rose && i > 0 && i < hold) begin
        rises++;
        if (rises == dly && trig < 0) trig = i;
      end
    end
    valid = m1 && (trig >= 0) && (trig <= hold - 2);
    if (is_wr && valid) model[port*DW +: DW] = val;
    chk(wr_data == model, "R3", "wr_data bank", NP'(wr_data[port*DW +: DW]),
        NP'(model[port*DW +: DW]));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit rose;
    for (int p = 0; p < NP; p++) rd_port_data[p*DW +: DW] = rd_pat(p);
    model = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(wr_strobe == '0, "R10", "wr_strobe reset", wr_strobe, '0);
    chk(rd_strobe == '0, "R10", "rd_strobe reset", rd_strobe, '0);
    chk(wr_data == '0, "R10", "wr_data reset", NP'(wr_data[DW-1:0]), '0);
    chk(data_oe == 1'b0 && data_o == '0, "R10", "read path reset", NP'(data_o), '0);
    bus_step(rose);

    // R7 R2 R3 R8: write sweep over every port
    for (int p = 0; p < NP; p++) io_cycle(1'b1, p, DW'(p * 7 + 3), 40, 1'b1, "R7");
    // R3: overwrite one port, neighbours untouched
    io_cycle(1'b1, 17, 8'hC3, 40, 1'b1, "R3");
    io_cycle(1'b1, 17, 8'h3C, 40, 1'b1, "R3");
    // R6 R4 R5: read sweep over every port
    for (int p = 0; p < NP; p++) io_cycle(1'b0, p, 8'h00, 40, 1'b1, "R6");
    // R1: acknowledge-type cycles (m1 low) are ignored
    io_cycle(1'b1, 245, 8'hEE, 40, 1'b0, "R1");
    io_cycle(1'b0, 245, 8'h00, 40, 1'b0, "R1");
    // R9: command dropped before the delay elapses
    io_cycle(1'b1, 100, 8'h99, 5, 1'b1, "R9");
    io_cycle(1'b0, 242, 8'h00, 5, 1'b1, "R9");
    // R2/R4: long command still yields a single strobe
    io_cycle(1'b1, 255, 8'h81, 90, 1'b1, "R2");
    io_cycle(1'b0, 249, 8'h00, 90, 1'b1, "R4");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule